// File: doc/BRIEF.md
# Two-Step Flash Conversion Decoder

This block sequences and decodes a two-pass flash analog-to-digital conversion. A coarse bank of six estimator comparators gives a rough idea of where the input lies. From that estimate, the block picks a window of 16 consecutive taps on a 64-tap main ladder. The window is wider than the estimate's own region, so an estimator error of up to 1/16 of full scale is absorbed. A single bank of 16 comparators is first pointed at that window to find the six most significant bits. The same bank is then pointed at a 16-step fine ladder, which receives the input minus the coarse tap, to find the four least significant bits.

A conversion begins with a one-cycle `start` pulse while the block is idle. The block then walks through estimate, coarse and fine phases, one clock each. It publishes the window start and the coarse tap so the analog multiplexers can route the shared comparators. At the end it latches the 10-bit result and raises `done` for one cycle. Both comparator inputs are decoded by counting the ones they hold, so a thermometer code with a bubble still decodes to its population.

Top module: `twostep_flash_decoder`

## Requirements
- R1: While `rstN` is low, `phase` is 0 (idle), `done` is 0, and `result`, `winStart` and `coarseTap` are all 0.
- R2: A high `start` sampled in idle moves `phase` through 1 (estimate), 2 (coarse), 3 (fine), 4 (done) and back to 0 on successive clocks. `phase` stays 0 while `start` is low.
- R3: `start` has no effect unless `phase` is 0. A conversion in flight is neither restarted nor lengthened.
- R4: The `estComp` value sampled in the estimate phase sets `winStart` at the next clock. With k ones counted in `estComp`, `winStart` is 0 when k is 0 and 8*k otherwise, which is never above 48. Estimator bit i nominally trips at (2i+3)/16 of full scale.
- R5: `estComp` and `bankComp` are decoded by the number of ones they hold, not by where the first 0-to-1 transition sits. Swapping the two bits at the top of a thermometer code leaves the result unchanged.
- R6: With c ones on `bankComp` in the coarse phase, `coarseTap` becomes `winStart` + c - 1, floored at 0 and saturated at 63. In particular, c = 0 gives `winStart` - 1.
- R7: When each estimator threshold is off by less than 64 codes, the final result equals the input code exactly.
- R8: In the fine phase, `bankComp` bit k means the residue is at least k+1 fine steps. The four low result bits equal the count of ones, saturated at 15.
- R9: `result` is {`coarseTap`, fine count}. It is latched at the end of the fine phase and holds its value at every other clock.
- R10: `done` is high for exactly the one cycle in which `phase` is 4, and `result` is valid in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a conversion (sampled in idle only) |
| estComp | input | 6 | Estimator comparator outputs, bit i for threshold i |
| bankComp | input | 16 | Shared comparator bank outputs |
| winStart | output | 6 | First main-ladder tap of the coarse window |
| coarseTap | output | 6 | Coarse tap, subtracted from the input for the fine pass |
| phase | output | 3 | Sequencer phase: 0 idle, 1 estimate, 2 coarse, 3 fine, 4 done |
| result | output | 10 | Latched conversion result |
| done | output | 1 | One-cycle completion pulse |

## Verification
The embedded properties assume that the comparator inputs are valid for the phase in which they are sampled. The coarse-tap property also assumes that the bank reports at least one tripped comparator whenever the window holds the input. The bench meets these assumptions with a behavioural ladder model that responds to `phase`, `winStart` and `coarseTap`, given random input codes and random estimator offsets kept under 64 codes. Directed cases then step outside them on purpose: a forced all-ones estimate with a zero input gives an empty coarse bank. Other directed cases cover bubbles at the top of each thermometer code and `start` held high through a conversion.

// File: rtl/twostep_pkg.sv
package twostep_pkg;

  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_EST    = 3'd1,
    PH_COARSE = 3'd2,
    PH_FINE   = 3'd3,
    PH_DONE   = 3'd4
  } phase_t;

  // Strobes from control to datapath: one per capture point.
  typedef struct packed {
    logic takeEst;
    logic takeCoarse;
    logic takeFine;
  } strobe_t;

endpackage

// File: rtl/twostep_ones.sv
module twostep_ones #(
  parameter int N = 16,
  localparam int CW = $clog2(N + 1)
) (
  input  logic [N-1:0]  bits,
  output logic [CW-1:0] count
);

  // Population count: a bubble shifts no weight, only its position.
  always_comb begin
    count = '0;
    for (int i = 0; i < N; i++) begin
      count = count + CW'(bits[i]);
    end
  end

endmodule

// File: rtl/twostep_ctrl.sv
module twostep_ctrl
  import twostep_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  output phase_t  stateQ,
  output strobe_t strb,
  output logic    done
);

  phase_t stateD;

  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      PH_IDLE:   if (start) stateD = PH_EST;
      PH_EST:    stateD = PH_COARSE;
      PH_COARSE: stateD = PH_FINE;
      PH_FINE:   stateD = PH_DONE;
      PH_DONE:   stateD = PH_IDLE;
      default:   stateD = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= PH_IDLE;
    else       stateQ <= stateD;
  end

  always_comb begin
    strb.takeEst    = (stateQ == PH_EST);
    strb.takeCoarse = (stateQ == PH_COARSE);
    strb.takeFine   = (stateQ == PH_FINE);
  end

  assign done = (stateQ == PH_DONE);

  // R2: fixed phase order, one phase per clock
  a_r2_est_to_coarse: assert property (@(posedge clk) disable iff (!rstN)
    stateQ == PH_EST |=> stateQ == PH_COARSE);
  a_r2_coarse_to_fine: assert property (@(posedge clk) disable iff (!rstN)
    stateQ == PH_COARSE |=> stateQ == PH_FINE);
  a_r2_fine_to_done: assert property (@(posedge clk) disable iff (!rstN)
    stateQ == PH_FINE |=> stateQ == PH_DONE);
  a_r2_idle_waits: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == PH_IDLE && !start) |=> stateQ == PH_IDLE);
  // R3: no restart while busy
  a_r3_busy_no_restart: assert property (@(posedge clk) disable iff (!rstN)
    stateQ != PH_IDLE |=> stateQ != PH_EST);
  // R10: single-cycle completion pulse
  a_r10_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

endmodule

// File: rtl/twostep_datapath.sv
module twostep_datapath
  import twostep_pkg::*;
#(
  parameter int EST_N    = 6,
  parameter int BANK_N   = 16,
  parameter int COARSE_W = 6,
  parameter int FINE_W   = 4,
  localparam int RES_W   = COARSE_W + FINE_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  strobe_t             strb,
  input  logic [EST_N-1:0]    estComp,
  input  logic [BANK_N-1:0]   bankComp,
  output logic [COARSE_W-1:0] winStartQ,
  output logic [COARSE_W-1:0] coarseQ,
  output logic [RES_W-1:0]    resultQ
);

  localparam int TAPS      = 1 << COARSE_W;
  localparam int MARGIN    = TAPS / 16;
  localparam int MAX_START = TAPS - BANK_N;
  localparam int FINE_MAX  = (1 << FINE_W) - 1;
  localparam int ECW       = $clog2(EST_N + 1);
  localparam int BCW       = $clog2(BANK_N + 1);

  logic [ECW-1:0]      estCount;
  logic [BCW-1:0]      bankCount;
  logic [COARSE_W-1:0] winStartD;
  logic [COARSE_W-1:0] coarseD;
  logic [FINE_W-1:0]   fineD;

  twostep_ones #(.N(EST_N))  uEstCount  (.bits(estComp),  .count(estCount));
  twostep_ones #(.N(BANK_N)) uBankCount (.bits(bankComp), .count(bankCount));

  // Region k spans (2k+1)/16 upward; window opens one margin below it.
  always_comb begin
    int lower;
    int s;
    lower = (estCount == '0) ? 0 : (2 * int'(estCount) + 1) * MARGIN;
    s = lower - MARGIN;
    if (s < 0) s = 0;
    if (s > MAX_START) s = MAX_START;
    winStartD = COARSE_W'(s);
  end

  always_comb begin
    int cv;
    cv = int'(winStartQ) + int'(bankCount) - 1;
    if (cv < 0) cv = 0;
    if (cv > TAPS - 1) cv = TAPS - 1;
    coarseD = COARSE_W'(cv);
  end

  always_comb begin
    int fv;
    fv = int'(bankCount);
    if (fv > FINE_MAX) fv = FINE_MAX;
    fineD = FINE_W'(fv);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      winStartQ <= '0;
      coarseQ   <= '0;
      resultQ   <= '0;
    end else begin
      if (strb.takeEst)    winStartQ <= winStartD;
      if (strb.takeCoarse) coarseQ   <= coarseD;
      if (strb.takeFine)   resultQ   <= {coarseQ, fineD};
    end
  end

  // R4: window never runs off the top of the ladder
  a_r4_window_in_range: assert property (@(posedge clk) disable iff (!rstN)
    int'(winStartQ) <= MAX_START);
  // R6: a non-empty bank places the coarse tap inside the window
  a_r6_coarse_in_window: assert property (@(posedge clk) disable iff (!rstN)
    (strb.takeCoarse && bankCount != '0) |=>
      (coarseQ >= winStartQ && int'(coarseQ) <= int'(winStartQ) + BANK_N - 1));

endmodule

// File: rtl/twostep_flash_decoder.sv
module twostep_flash_decoder
  import twostep_pkg::*;
#(
  parameter int EST_N    = 6,
  parameter int BANK_N   = 16,
  parameter int COARSE_W = 6,
  parameter int FINE_W   = 4,
  localparam int RES_W   = COARSE_W + FINE_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                start,
  input  logic [EST_N-1:0]    estComp,
  input  logic [BANK_N-1:0]   bankComp,
  output logic [COARSE_W-1:0] winStart,
  output logic [COARSE_W-1:0] coarseTap,
  output logic [2:0]          phase,
  output logic [RES_W-1:0]    result,
  output logic                done
);

  phase_t  stateQ;
  strobe_t strb;

  twostep_ctrl uCtrl (
    .clk   (clk),
    .rstN  (rstN),
    .start (start),
    .stateQ(stateQ),
    .strb  (strb),
    .done  (done)
  );

  twostep_datapath #(
    .EST_N   (EST_N),
    .BANK_N  (BANK_N),
    .COARSE_W(COARSE_W),
    .FINE_W  (FINE_W)
  ) uData (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .estComp  (estComp),
    .bankComp (bankComp),
    .winStartQ(winStart),
    .coarseQ  (coarseTap),
    .resultQ  (result)
  );

  assign phase = stateQ;

  // R9: result moves only at the end of the fine phase
  a_r9_result_hold: assert property (@(posedge clk) disable iff (!rstN)
    phase != 3'(PH_FINE) |=> $stable(result));
  // R9: upper result bits carry the coarse tap
  a_r9_msb_is_coarse: assert property (@(posedge clk) disable iff (!rstN)
    done |-> result[RES_W-1:FINE_W] == coarseTap);

endmodule

// File: tb/twostep_flash_decoder_test.sv
module twostep_flash_decoder_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [5:0]  estComp;
  logic [15:0] bankComp;
  logic [5:0]  winStart;
  logic [5:0]  coarseTap;
  logic [2:0]  phase;
  logic [9:0]  result;
  logic        done;

  int testsRun = 0;
  int testsFailed = 0;

  // analog stand-in
  int  vIn = 0;
  int  estOff [6];
  bit  estForce = 1'b0;
  logic [5:0] estForceVal = '0;
  bit  estBubble = 1'b0;
  bit  bankBubble = 1'b0;
  int  mdlN, mdlC, mdlRes;

  always #2 clk = ~clk;

  twostep_flash_decoder uut (
    .clk(clk), .rstN(rstN), .start(start),
    .estComp(estComp), .bankComp(bankComp),
    .winStart(winStart), .coarseTap(coarseTap),
    .phase(phase), .result(result), .done(done)
  );

  always_comb begin
    for (int i = 0; i < 6; i++) estComp[i] = (vIn >= (2 * i + 3) * 64 + estOff[i]);
    if (estForce) estComp = estForceVal;
    mdlN = 0;
    for (int i = 0; i < 6; i++) mdlN = mdlN + int'(estComp[i]);
    if (estBubble && mdlN >= 1 && mdlN <= 5) begin
      estComp[mdlN - 1] = 1'b0;
      estComp[mdlN] = 1'b1;
    end
    if (phase == 3'd3) begin
      mdlRes = vIn - int'(coarseTap) * 16;
      for (int k = 0; k < 16; k++) bankComp[k] = (mdlRes >= k + 1);
    end else begin
      for (int j = 0; j < 16; j++) bankComp[j] = (vIn >= (int'(winStart) + j) * 16);
      mdlC = 0;
      for (int j = 0; j < 16; j++) mdlC = mdlC + int'(bankComp[j]);
      if (bankBubble && mdlC >= 1 && mdlC <= 15) begin
        bankComp[mdlC - 1] = 1'b0;
        bankComp[mdlC] = 1'b1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int expWindow(input int v);
    int n = 0;
    for (int i = 0; i < 6; i++) if (v >= (2 * i + 3) * 64 + estOff[i]) n++;
    return (n == 0) ? 0 : 8 * n;
  endfunction

  task automatic runConv(input int v, input int eWin, input int eCoarse, input int eRes);
    @(negedge clk);
    vIn = v;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(phase == 3'd1, "R2 estimate phase", phase, 1);
    @(negedge clk);
    chk(phase == 3'd2, "R2 coarse phase", phase, 2);
    chk(winStart == 6'(eWin), "R4 window start", winStart, eWin);
    @(negedge clk);
    chk(phase == 3'd3, "R2 fine phase", phase, 3);
    chk(coarseTap == 6'(eCoarse), "R6 coarse tap", coarseTap, eCoarse);
    @(negedge clk);
    chk(done === 1'b1 && phase == 3'd4, "R10 done with phase 4", done, 1);
    chk(result == 10'(eRes), "R9 R7 R8 result", result, eRes);
    @(negedge clk);
    chk(done === 1'b0 && phase == 3'd0, "R10 done drops", done, 0);
    @(negedge clk);
    chk(result == 10'(eRes), "R9 result held", result, eRes);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    testsFailed++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 6; i++) estOff[i] = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(phase == 3'd0 && done == 1'b0, "R1 reset phase/done", phase, 0);
    chk(result == 10'd0 && winStart == 6'd0 && coarseTap == 6'd0, "R1 reset regs", result, 0);
    rstN = 1'b1;
    // R2 idle without start
    repeat (3) @(negedge clk);
    chk(phase == 3'd0, "R2 idle holds", phase, 0);

    // directed corners (R4, R7, R8)
    runConv(0, 0, 0, 0);
    runConv(1023, 48, 63, 1023);
    runConv(191, 0, 11, 191);
    runConv(192, 8, 12, 192);
    runConv(833, 48, 52, 833);
    // R7 estimator errors near the limit
    for (int i = 0; i < 6; i++) estOff[i] = 63;
    runConv(318, expWindow(318), 318 / 16, 318);
    for (int i = 0; i < 6; i++) estOff[i] = -63;
    runConv(258, expWindow(258), 258 / 16, 258);
    for (int i = 0; i < 6; i++) estOff[i] = 0;

    // R5 bubbles at the top of each thermometer code
    estBubble = 1'b1;
    runConv(600, 32, 37, 600);
    estBubble = 1'b0;
    bankBubble = 1'b1;
    runConv(455, 24, 28, 455);
    bankBubble = 1'b0;

    // R6 empty coarse bank: forced all-ones estimate with zero input
    estForce = 1'b1;
    estForceVal = 6'h3F;
    runConv(0, 48, 47, 47 * 16);
    estForce = 1'b0;

    // R3 start held through a conversion
    @(negedge clk);
    vIn = 700;
    start = 1'b1;
    @(negedge clk);
    chk(phase == 3'd1, "R3 estimate", phase, 1);
    @(negedge clk);
    chk(phase == 3'd2, "R3 no restart in coarse", phase, 2);
    @(negedge clk);
    chk(phase == 3'd3, "R3 no restart in fine", phase, 3);
    start = 1'b0;
    @(negedge clk);
    chk(phase == 3'd4 && result == 10'd700, "R3 completes normally", result, 700);
    repeat (2) @(negedge clk);

    // random inputs with estimator offsets under 64 codes (R4, R7)
    for (int t = 0; t < 150; t++) begin
      int v;
      v = int'($urandom % 1024);
      for (int i = 0; i < 6; i++) estOff[i] = int'($urandom % 127) - 63;
      estBubble = ($urandom % 4) == 0;
      bankBubble = ($urandom % 4) == 0;
      runConv(v, expWindow(v), v / 16, v);
    end

    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule